// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Packed Flags

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator machine. Each evaluation takes the current accumulator, a second operand, the current flag byte and a 4-bit operation selector. It returns an 8-bit result, a write-enable that tells the surrounding datapath whether the accumulator should take that result, and the next flag byte. The accumulator is the first operand of every two-operand operation and the only destination.

The operations are binary add and subtract (each with an optional carry or borrow in), compare, the three bitwise logic operations, accumulator increment and decrement, ones' complement, two's-complement negate, carry toggle, carry set, and a decimal adjust. The decimal adjust corrects the accumulator after a packed-BCD add or subtract, using the half-carry, subtract and carry flags left by that operation. Bit 2 of the flag byte carries signed overflow after arithmetic and even parity after logic and decimal adjust. Flag bits 5 and 3 are not defined by this block and are carried through from the input unchanged.

There is no clock, state or handshake inside the block. The owner of the accumulator and flag registers samples the outputs at its own clock edge.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i`: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 increment, 9 decrement, 10 complement, 11 negate, 12 toggle carry, 13 set carry, 14 decimal adjust, 15 no operation. `acc_we_o` is 1 for codes 0-6, 8-11 and 14, and 0 for codes 7, 12, 13 and 15. Flag byte positions: carry bit 0, subtract bit 1, parity/overflow bit 2, half-carry bit 4, zero bit 6, sign bit 7.
- R2: Add (0) and add-with-carry (1) return (acc + opnd + cin) mod 256, where cin is `flags_i` bit 0 for code 1 and 0 for code 0. Carry = carry out of bit 7, half-carry = carry out of bit 3, bit 2 = signed overflow, subtract flag = 0.
- R3: Subtract (2), subtract-with-borrow (3) and compare (7) compute acc − opnd − cin, where cin is `flags_i` bit 0 for code 3 only. Carry = borrow out of bit 7, half-carry = borrow out of bit 3, bit 2 = signed overflow, subtract flag = 1. Compare shows the difference on `result_o` but never writes the accumulator.
- R4: For codes 0-11 and 14, sign = bit 7 of `result_o` and zero = 1 exactly when `result_o` is 0.
- R5: AND, XOR and OR return the bitwise result. Half-carry is 1 for AND and 0 for XOR and OR. Carry and subtract are 0, and bit 2 is 1 when the result has an even number of one bits.
- R6: Increment (8) and decrement (9) return acc ± 1 mod 256 and leave carry equal to `flags_i` bit 0. Half-carry is the nibble carry or borrow, bit 2 is 1 only for 0x7F→0x80 (increment) or 0x80→0x7F (decrement), and subtract is 0 for increment and 1 for decrement.
- R7: Complement (10) returns the bitwise inverse of the accumulator and sets half-carry and subtract to 1. Sign, zero, parity/overflow and carry are left at their input values... except that R4 updates sign and zero from the result.
- R8: Negate (11) returns (0 − acc) mod 256. Carry is 1 when acc ≠ 0, half-carry is 1 when acc bits 3:0 ≠ 0, bit 2 is 1 only when acc = 0x80, and subtract = 1.
- R9: Toggle carry (12) inverts carry and copies the old carry into half-carry. Set carry (13) sets carry and clears half-carry. Both clear subtract, keep sign, zero and bit 2, and drive `result_o` with the accumulator.
- R10: Decimal adjust (14) forms a correction: 0x06 if half-carry is set or acc bits 3:0 > 9, and 0x60 if carry is set or acc > 0x99. It subtracts the correction when the subtract flag is 1 and adds it otherwise. The new carry is 1 when 0x60 was applied and 0 otherwise. The new half-carry is (old half-carry and acc bits 3:0 < 6) when subtracting, or (acc bits 3:0 > 9) when adding. Bit 2 is even parity, and subtract is unchanged.
- R11: Flag bits 5 and 3 of `flags_o` always equal those of `flags_i`. Code 15 returns `flags_o` = `flags_i` and `result_o` = the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator, first operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| op_i | input | 4 | Operation code (see R1) |
| result_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Accumulator write-enable |
| flags_o | output | 8 | Next flag byte |

## Verification
Every output of this block is due in the same cycle as its inputs, with zero register stages between them. The bench therefore drives one vector just after a rising edge of its own clock and samples all three outputs at the following falling edge, half a period later, once the logic has settled. The binary operations are swept over every accumulator value against a strided set of operands, with the incoming carry varying between vectors. The unary operations and the decimal adjust are swept over every accumulator value under each combination of the flags they read.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_INV  = 4'd10,
    OP_NEG  = 4'd11,
    OP_TGLC = 4'd12,
    OP_SETC = 4'd13,
    OP_BCDA = 4'd14,
    OP_IDLE = 4'd15
  } alu_op_e;

  // flag byte positions
  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_H  = 4;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;

  function automatic logic even_parity8(input logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int HW = W / 2;

  logic [W-1:0] b_eff;
  logic         ci;
  logic [HW:0]  low;
  logic [W:0]   full;

  // subtraction as a + ~b + ~borrow; carries are inverted back to borrows
  assign b_eff = sub_i ? ~b_i : b_i;
  assign ci    = sub_i ^ cin_i;
  assign low   = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci};
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ci};

  assign sum_o   = full[W-1:0];
  assign carry_o = full[W] ^ sub_i;
  assign half_o  = low[HW] ^ sub_i;
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  alu8_pkg::alu_op_e op_i,
  output logic [W-1:0]     res_o,
  output logic             half_o
);
  import alu8_pkg::*;

  always_comb begin
    res_o  = a_i | b_i;
    half_o = 1'b0;
    case (op_i)
      OP_AND: begin
        res_o  = a_i & b_i;
        half_o = 1'b1;
      end
      OP_XOR: res_o = a_i ^ b_i;
      default: ;
    endcase
  end

  always_comb begin
    // R5
    and_subset_chk: assert ((op_i != OP_AND) || ((res_o & ~(a_i & b_i)) == '0))
      else $error("AND result has a bit not set in both operands");
  end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         n_i,
  input  logic         h_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         h_o,
  output logic         c_o
);
  localparam int HW = W / 2;
  localparam logic [W-1:0]  BCD_LIM = W'(8'h99);
  localparam logic [HW-1:0] DIG_MAX = HW'(4'd9);
  localparam logic [HW-1:0] DIG_SIX = HW'(4'd6);

  logic [HW-1:0] lo;
  logic          fix_lo, fix_hi;
  logic [W-1:0]  corr;

  assign lo     = a_i[HW-1:0];
  assign fix_lo = h_i || (lo > DIG_MAX);
  assign fix_hi = c_i || (a_i > BCD_LIM);
  assign corr   = {(fix_hi ? DIG_SIX : {HW{1'b0}}), (fix_lo ? DIG_SIX : {HW{1'b0}})};
  assign res_o  = n_i ? (a_i - corr) : (a_i + corr);
  assign c_o    = fix_hi;
  assign h_o    = n_i ? (h_i && (lo < DIG_SIX)) : (lo > DIG_MAX);

  always_comb begin
    // R10
    daa_carry_sticky_chk: assert (!c_i || c_o)
      else $error("decimal adjust cleared an incoming carry");
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [7:0]        flags_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [7:0]        flags_o
);
  import alu8_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // main two-operand adder
  logic              m_sub, m_cin;
  logic [DATA_W-1:0] m_sum;
  logic              m_c, m_h, m_v;
  assign m_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign m_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flags_i[FL_C] : 1'b0;

  alu8_addsub #(.W(DATA_W)) u_main (
    .a_i(acc_i), .b_i(opnd_i), .cin_i(m_cin), .sub_i(m_sub),
    .sum_o(m_sum), .carry_o(m_c), .half_o(m_h), .ovf_o(m_v)
  );

  // increment / decrement of the accumulator
  logic [DATA_W-1:0] u_sum;
  logic              u_c, u_h, u_v;
  alu8_addsub #(.W(DATA_W)) u_step (
    .a_i(acc_i), .b_i(DATA_W'(1)), .cin_i(1'b0), .sub_i(op == OP_DEC),
    .sum_o(u_sum), .carry_o(u_c), .half_o(u_h), .ovf_o(u_v)
  );

  // negate: zero minus accumulator
  logic [DATA_W-1:0] n_sum;
  logic              n_c, n_h, n_v;
  alu8_addsub #(.W(DATA_W)) u_neg (
    .a_i({DATA_W{1'b0}}), .b_i(acc_i), .cin_i(1'b0), .sub_i(1'b1),
    .sum_o(n_sum), .carry_o(n_c), .half_o(n_h), .ovf_o(n_v)
  );

  logic [DATA_W-1:0] lg_res;
  logic              lg_h;
  alu8_logic #(.W(DATA_W)) u_logic (
    .a_i(acc_i), .b_i(opnd_i), .op_i(op), .res_o(lg_res), .half_o(lg_h)
  );

  logic [DATA_W-1:0] d_res;
  logic              d_h, d_c;
  alu8_daa #(.W(DATA_W)) u_daa (
    .a_i(acc_i), .n_i(flags_i[FL_N]), .h_i(flags_i[FL_H]), .c_i(flags_i[FL_C]),
    .res_o(d_res), .h_o(d_h), .c_o(d_c)
  );

  logic set_sz;
  logic [7:0] fl;
  logic [DATA_W-1:0] res;
  logic we;

  always_comb begin
    fl     = flags_i;
    res    = acc_i;
    we     = 1'b0;
    set_sz = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin
        res = m_sum; we = 1'b1;
        fl[FL_C] = m_c; fl[FL_H] = m_h; fl[FL_PV] = m_v; fl[FL_N] = 1'b0;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res = m_sum; we = (op != OP_CMP);
        fl[FL_C] = m_c; fl[FL_H] = m_h; fl[FL_PV] = m_v; fl[FL_N] = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res = lg_res; we = 1'b1;
        fl[FL_C] = 1'b0; fl[FL_H] = lg_h; fl[FL_N] = 1'b0;
        fl[FL_PV] = even_parity8(8'(lg_res));
      end
      OP_INC, OP_DEC: begin
        res = u_sum; we = 1'b1;
        fl[FL_H] = u_h; fl[FL_PV] = u_v; fl[FL_N] = (op == OP_DEC);
      end
      OP_INV: begin
        res = ~acc_i; we = 1'b1;
        fl[FL_H] = 1'b1; fl[FL_N] = 1'b1;
      end
      OP_NEG: begin
        res = n_sum; we = 1'b1;
        fl[FL_C] = n_c; fl[FL_H] = n_h; fl[FL_PV] = n_v; fl[FL_N] = 1'b1;
      end
      OP_TGLC: begin
        set_sz = 1'b0;
        fl[FL_H] = flags_i[FL_C]; fl[FL_C] = ~flags_i[FL_C]; fl[FL_N] = 1'b0;
      end
      OP_SETC: begin
        set_sz = 1'b0;
        fl[FL_C] = 1'b1; fl[FL_H] = 1'b0; fl[FL_N] = 1'b0;
      end
      OP_BCDA: begin
        res = d_res; we = 1'b1;
        fl[FL_C] = d_c; fl[FL_H] = d_h;
        fl[FL_PV] = even_parity8(8'(d_res));
      end
      default: set_sz = 1'b0;
    endcase
    if (set_sz) begin
      fl[FL_S] = res[DATA_W-1];
      fl[FL_Z] = (res == '0);
    end
  end

  assign result_o = res;
  assign acc_we_o = we;
  assign flags_o  = fl;

  always_comb begin
    // R11
    undef_bits_pass_chk: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
      else $error("flag bits 5/3 altered");
    // R3
    cmp_no_write_chk: assert ((op != OP_CMP) || (!acc_we_o && flags_o[FL_N]))
      else $error("compare wrote accumulator or cleared subtract flag");
    // R6
    step_carry_keep_chk: assert (!(op == OP_INC || op == OP_DEC) || (flags_o[FL_C] == flags_i[FL_C]))
      else $error("increment/decrement changed carry");
    // R6
    inc_wrap_chk: assert (!(op == OP_INC && u_c) || (result_o == '0 && flags_o[FL_Z]))
      else $error("increment carry out without zero result");
    // R4
    zero_flag_chk: assert (!set_sz || (flags_o[FL_Z] == (result_o == '0)))
      else $error("zero flag disagrees with result");
    // R5
    logic_parity_chk: assert (!(op == OP_AND || op == OP_OR || op == OP_XOR)
                              || (flags_o[FL_PV] == ~(^result_o)))
      else $error("logic parity flag wrong");
  end

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] acc, opnd, fin;
  logic [3:0] op;
  logic [7:0] res;
  logic       we;
  logic [7:0] fout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  alu8_core u_alu8_core (
    .acc_i(acc), .opnd_i(opnd), .flags_i(fin), .op_i(op),
    .result_o(res), .acc_we_o(we), .flags_o(fout)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic bit par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) & 1) n++;
    return (n % 2) == 0;
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R2";
      2, 3, 7: return "R3";
      4, 5, 6: return "R5";
      8, 9: return "R6";
      10: return "R7";
      11: return "R8";
      12, 13: return "R9";
      14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input int o, input int a, input int b, input int f,
                       output int r, output bit w, output int fo);
    int cin, t, lo, corr;
    bit c, h, v, n, s_z;
    fo = f; r = a; w = 1'b0; s_z = 1'b1;
    c = f[0]; h = f[4]; v = f[2]; n = f[1];
    case (o)
      0, 1: begin
        cin = (o == 1) ? f[0] : 0;
        t = a + b + cin; r = t % 256; w = 1;
        c = t > 255; h = (a % 16 + b % 16 + cin) > 15;
        t = sgn(a) + sgn(b) + cin; v = (t > 127) || (t < -128); n = 0;
      end
      2, 3, 7: begin
        cin = (o == 3) ? f[0] : 0;
        t = a - b - cin; r = (t + 512) % 256; w = (o != 7);
        c = t < 0; h = (a % 16 - b % 16 - cin) < 0;
        t = sgn(a) - sgn(b) - cin; v = (t > 127) || (t < -128); n = 1;
      end
      4, 5, 6: begin
        r = (o == 4) ? (a & b) : (o == 5) ? (a ^ b) : (a | b);
        w = 1; c = 0; n = 0; h = (o == 4); v = par_even(r);
      end
      8: begin r = (a + 1) % 256; w = 1; h = (a % 16) == 15; v = a == 127; n = 0; end
      9: begin r = (a + 255) % 256; w = 1; h = (a % 16) == 0; v = a == 128; n = 1; end
      10: begin r = 255 - a; w = 1; h = 1; n = 1; end
      11: begin r = (256 - a) % 256; w = 1; c = a != 0; h = (a % 16) != 0; v = a == 128; n = 1; end
      12: begin s_z = 0; h = f[0]; c = !f[0]; n = 0; end
      13: begin s_z = 0; c = 1; h = 0; n = 0; end
      14: begin
        lo = a % 16; corr = 0;
        if (f[4] || lo > 9) corr += 6;
        if (f[0] || a > 153) corr += 96;
        r = f[1] ? (a - corr + 256) % 256 : (a + corr) % 256; w = 1;
        c = (f[0] || a > 153);
        h = f[1] ? (f[4] && lo < 6) : (lo > 9);
        v = par_even(r);
      end
      default: s_z = 0;
    endcase
    fo[0] = c; fo[1] = n; fo[2] = v; fo[4] = h;
    if (s_z) begin fo[7] = (r >= 128); fo[6] = (r == 0); end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s op=%0d acc=%02h opnd=%02h fin=%02h actual=%0h expected=%0h",
               tag, what, op, acc, opnd, fin, act, exp);
    end
  endtask

  task automatic run(input int o, input int a, input int b, input int f);
    int er, efo;
    bit ew;
    @(posedge clk);
    op = 4'(o); acc = 8'(a); opnd = 8'(b); fin = 8'(f);
    @(negedge clk);
    model(o, a, b, f, er, ew, efo);
    chk("R1", "acc_we", int'(we), int'(ew));
    chk(tag_of(o), "flags", int'(fout), efo);
    if (ew || o == 7 || o >= 12) chk(tag_of(o), "result", int'(res), er);
    if (o <= 11 || o == 14) chk("R4", "sign/zero", int'(fout[7:6]), (efo >> 6) & 3);
    chk("R11", "bits5_3", int'({fout[5], fout[3]}), int'({fin[5], fin[3]}));
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected<=190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    acc = 0; opnd = 0; fin = 0; op = 4'd15;
    // idle state at start
    run(15, 0, 0, 0);
    // fixed corners: R2 carry/overflow, R3 borrow, R8 negate 0x80, R10 BCD
    run(0, 8'h7F, 8'h01, 0);
    run(0, 8'hFF, 8'h01, 0);
    run(3, 8'h00, 8'h00, 1);
    run(11, 8'h80, 0, 0);
    run(14, 8'h9A, 0, 0);
    // binary sweep: every accumulator, strided operand, varying incoming flags
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 7)
          run(o, a, b, (a ^ (b << 1) ^ 8'hA5) & 255);
    // unary sweep: R6 R7 R8 R9 R11 under four flag patterns
    for (int o = 8; o < 14; o++)
      for (int a = 0; a < 256; a++)
        for (int p = 0; p < 4; p++)
          run(o, a, a ^ 8'h3C, (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h29 : 8'hD6);
    for (int a = 0; a < 256; a++) run(15, a, 255 - a, a ^ 8'h5A);
    // decimal adjust, every accumulator with every subtract/half/carry combination (R10)
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 8; k++)
        run(14, a, 0, ((k & 1) ? 8'h01 : 8'h00) | ((k & 2) ? 8'h02 : 8'h00)
                      | ((k & 4) ? 8'h10 : 8'h00) | (a & 8'h28));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule